// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block is the digital control in front of a battery-backed static memory. A sampled supply-fail flag, one of two offered by a comparator with different tolerance thresholds, is synchronized and used to decide whether host strobes may reach the array. While power is good, the host chip-enable, write-enable and output-enable pass through to the array and to the data-bus drive control. When a power failure is seen, a host write already under way may run to completion within a bounded grace window. Protection then becomes unconditional: array strobes are held inactive, the data bus is not driven, and every host input is ignored.

When the flag clears, the block keeps the array protected for a recovery delay before it reports ready again. A second synchronized flag, marking the supply below the battery switch-over level, selects the backup source. A sticky arm latch keeps the backup isolated until valid power has been seen once after reset. All durations are parameters counted in clock cycles.

The controller has four states. LOCK: protected, the reset state. RECOVER: protected, counting the recovery delay. RUN: normal access. GRACE: power has failed, but the write in flight may finish. There are seven transitions. LOCK→RECOVER when the synchronized fail flag is low. RECOVER→LOCK when the flag rises again. RECOVER→RUN when the recovery count completes. RUN→GRACE when the flag rises during a host write or while the array reports busy. RUN→LOCK when the flag rises with nothing in flight. GRACE→LOCK when the in-flight cycle ends. GRACE→LOCK when the grace count completes.

Top module: `pfail_guard`

## Requirements
- R1: After reset the block is in LOCK: `ready` is 0, `arr_ce_n` and `arr_we_n` are 1, `dq_oe` is 0 and `bkup_sel` is 0.
- R2: Both comparator flags pass through a synchronizer of `SYNC_STAGES` (default 2) flops. A change of the selected fail flag before rising edge k is acted on by the state register at edge k+2, so even a one-cycle fail pulse seen in RUN ends in LOCK.
- R3: With `TOL10`=0 only `pf_tight` is honoured; with `TOL10`=1 only `pf_loose` is honoured. The other flag has no effect on any output.
- R4: In RUN, `ready` is 1, `arr_ce_n` follows `ce_n`, `arr_we_n` is 0 exactly when `ce_n` and `we_n` are both 0, and `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R5: When the fail flag is seen in RUN with no host write (`ce_n`=`we_n`=0) and `arr_busy`=0, the next state is LOCK. In LOCK, `ready`, `dq_oe` and every array strobe are inactive, whatever the host inputs are.
- R6: A host write active when the fail flag is seen continues in GRACE with strobes passed through. When `ce_n` or `we_n` rises, the array strobes go inactive at once and the block enters LOCK at the next edge. A write started after the failure is never passed.
- R7: GRACE lasts at most `WPT_CYC` cycles. After that the block enters LOCK even if the write is still held.
- R8: `arr_busy`=1 also counts as a cycle in flight. It holds GRACE, bounded by `WPT_CYC`, but does not itself enable any array strobe.
- R9: After the fail flag clears, RECOVER lasts exactly `REC_CYC` cycles before RUN. A failure seen during RECOVER returns to LOCK, and the count restarts from zero on the next recovery.
- R10: `bkup_sel` = arm latch AND synchronized `vlow`. The latch is set the first time the synchronized fail flag is seen low after reset and stays set until reset.
- R11: `arr_we_n` is never 0 in LOCK or RECOVER, not even for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running clock |
| rst_n | input | 1 | asynchronous active-low reset |
| pf_tight | input | 1 | supply-fail flag, narrow-tolerance threshold (asynchronous) |
| pf_loose | input | 1 | supply-fail flag, wide-tolerance threshold (asynchronous) |
| vlow | input | 1 | supply below battery switch-over level (asynchronous) |
| ce_n | input | 1 | host chip enable, active low |
| we_n | input | 1 | host write enable, active low |
| oe_n | input | 1 | host output enable, active low |
| arr_busy | input | 1 | array reports an internal cycle still running |
| arr_ce_n | output | 1 | gated chip enable to the array, active low |
| arr_we_n | output | 1 | gated write enable to the array, active low |
| dq_oe | output | 1 | drive enable for the read data bus |
| bkup_sel | output | 1 | select battery as array supply |
| ready | output | 1 | normal access permitted |

## Verification
The hardest situation to reach is GRACE ending at its exact boundary. The host write must be held open across the synchronizer delay and then for the whole grace count, and in a separate case released part-way. The stimulus first opens a write in RUN and raises the fail flag under it, so the failure arrives while the cycle is already in flight. It then either holds the write past `WPT_CYC` or releases `we_n` after a few cycles, and tries a fresh write afterwards. The bench also interrupts a recovery count and lets `arr_busy` alone hold GRACE, so both the restart of the recovery count and the strobe-less grace are reached.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

    typedef enum logic [1:0] {
        ST_LOCK    = 2'd0,
        ST_RECOVER = 2'd1,
        ST_RUN     = 2'd2,
        ST_GRACE   = 2'd3
    } pf_state_t;

endpackage

// File: rtl/pfail_sync.sv
module pfail_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= RST_VAL;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pfail_tmr.sv
module pfail_tmr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [CW-1:0] lim,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == lim);

endmodule

// File: rtl/pfail_fsm.sv
module pfail_fsm
    import pfail_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pf_s,
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      arr_busy,
    input  logic      tmr_done,
    output pf_state_t state,
    output logic      grace_wr,
    output logic      tmr_clr,
    output logic      tmr_en,
    output logic      ready
);

    pf_state_t nxt;
    logic      gwr_nxt;
    logic      host_wr;
    logic      in_flight;

    assign host_wr   = ~ce_n & ~we_n;
    assign in_flight = (grace_wr & host_wr) | arr_busy;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_LOCK;
            grace_wr <= 1'b0;
        end else begin
            state    <= nxt;
            grace_wr <= gwr_nxt;
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        gwr_nxt = grace_wr;
        unique case (state)
            ST_LOCK: begin
                if (!pf_s) nxt = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (pf_s)          nxt = ST_LOCK;
                else if (tmr_done) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (pf_s) begin
                    if (host_wr || arr_busy) begin
                        nxt     = ST_GRACE;
                        gwr_nxt = host_wr;
                    end else begin
                        nxt = ST_LOCK;
                    end
                end
            end
            ST_GRACE: begin
                gwr_nxt = grace_wr & host_wr;
                if (!in_flight || tmr_done) nxt = ST_LOCK;
            end
            default: nxt = ST_LOCK;
        endcase
        if (nxt != ST_GRACE) gwr_nxt = 1'b0;
    end

    // outputs
    always_comb begin
        tmr_clr = (nxt != state);
        tmr_en  = (state == ST_RECOVER) || (state == ST_GRACE);
        ready   = (state == ST_RUN);
    end

endmodule

// File: rtl/pfail_gate.sv
module pfail_gate
    import pfail_pkg::*;
(
    input  pf_state_t state,
    input  logic      grace_wr,
    input  logic      ce_n,
    input  logic      we_n,
    input  logic      oe_n,
    output logic      arr_ce_n,
    output logic      arr_we_n,
    output logic      dq_oe
);

    logic run;
    logic finish_wr;

    always_comb begin
        run       = (state == ST_RUN);
        finish_wr = (state == ST_GRACE) & grace_wr & ~ce_n & ~we_n;
        arr_we_n  = ~((run & ~ce_n & ~we_n) | finish_wr);
        arr_ce_n  = ~((run & ~ce_n) | finish_wr);
        dq_oe     = run & ~ce_n & ~oe_n & we_n;
    end

endmodule

// File: rtl/pfail_arm.sv
module pfail_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_s,
    input  logic vlow_s,
    output logic armed,
    output logic bkup_sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     armed <= 1'b0;
        else if (!pf_s) armed <= 1'b1;
    end

    assign bkup_sel = armed & vlow_s;

endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
    import pfail_pkg::*;
#(
    parameter bit TOL10       = 1'b0,
    parameter int SYNC_STAGES = 2,
    parameter int REC_CYC     = 64,
    parameter int WPT_CYC     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_tight,
    input  logic pf_loose,
    input  logic vlow,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    input  logic arr_busy,
    output logic arr_ce_n,
    output logic arr_we_n,
    output logic dq_oe,
    output logic bkup_sel,
    output logic ready
);

    localparam int MAXC = (REC_CYC > WPT_CYC) ? REC_CYC : WPT_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] REC_LIM = CW'(REC_CYC - 1);
    localparam logic [CW-1:0] WPT_LIM = CW'(WPT_CYC - 1);

    logic          pf_raw;
    logic          pf_s;
    logic          vlow_s;
    logic          armed;
    pf_state_t     st;
    logic          grace_wr;
    logic          tmr_clr;
    logic          tmr_en;
    logic          tmr_done;
    logic [CW-1:0] tmr_lim;

    assign pf_raw  = TOL10 ? pf_loose : pf_tight;
    assign tmr_lim = (st == ST_RECOVER) ? REC_LIM : WPT_LIM;

    pfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pf_sync (
        .clk(clk), .rst_n(rst_n), .d(pf_raw), .q(pf_s)
    );

    pfail_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_vl_sync (
        .clk(clk), .rst_n(rst_n), .d(vlow), .q(vlow_s)
    );

    pfail_tmr #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
        .lim(tmr_lim), .done(tmr_done)
    );

    pfail_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pf_s(pf_s), .ce_n(ce_n), .we_n(we_n),
        .arr_busy(arr_busy), .tmr_done(tmr_done), .state(st),
        .grace_wr(grace_wr), .tmr_clr(tmr_clr), .tmr_en(tmr_en),
        .ready(ready)
    );

    pfail_gate u_gate (
        .state(st), .grace_wr(grace_wr), .ce_n(ce_n), .we_n(we_n),
        .oe_n(oe_n), .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n),
        .dq_oe(dq_oe)
    );

    pfail_arm u_arm (
        .clk(clk), .rst_n(rst_n), .pf_s(pf_s), .vlow_s(vlow_s),
        .armed(armed), .bkup_sel(bkup_sel)
    );

endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk
    import pfail_pkg::*;
#(
    parameter int REC_CYC = 64,
    parameter int WPT_CYC = 16
) (
    input logic      clk,
    input logic      rst_n,
    input pf_state_t state,
    input logic      pf_s,
    input logic      armed,
    input logic      ready,
    input logic      arr_ce_n,
    input logic      arr_we_n,
    input logic      dq_oe,
    input logic      bkup_sel
);

    int rec_run;
    int gr_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_run <= 0;
            gr_run  <= 0;
        end else begin
            rec_run <= (state == ST_RECOVER) ? rec_run + 1 : 0;
            gr_run  <= (state == ST_GRACE)   ? gr_run + 1  : 0;
        end
    end

    p_lock_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK) |-> (arr_we_n && arr_ce_n && !dq_oe && !ready));

    p_no_write_protected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK || state == ST_RECOVER) |-> arr_we_n);

    p_fail_drops_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pf_s) |=> !ready);

    p_recovery_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (rec_run == REC_CYC));

    p_grace_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        gr_run <= WPT_CYC);

    p_arm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);

    p_backup_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !bkup_sel);

endmodule

bind pfail_guard pfail_guard_chk #(.REC_CYC(REC_CYC), .WPT_CYC(WPT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(st), .pf_s(pf_s), .armed(armed),
    .ready(ready), .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n),
    .dq_oe(dq_oe), .bkup_sel(bkup_sel)
);

// File: tb/pfail_guard_bench.sv
module pfail_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REC = 64;
    localparam int WPT = 16;
    localparam bit TOL = 1'b0;

    localparam int MD_LOCK = 0;
    localparam int MD_REC  = 1;
    localparam int MD_RUN  = 2;
    localparam int MD_GR   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pf_tight = 1'b1, pf_loose = 1'b1, vlow = 1'b1;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, arr_busy = 1'b0;
    logic arr_ce_n, arr_we_n, dq_oe, bkup_sel, ready;

    int    vectors = 0;
    int    misses  = 0;
    string tag     = "R1";

    // behavioural reference state
    int m_mode, m_cnt;
    bit m_gwr, m_arm, s1, s2, v1, v2;

    pfail_guard #(.TOL10(TOL), .SYNC_STAGES(2), .REC_CYC(REC), .WPT_CYC(WPT)) u_pfail_guard (
        .clk(clk), .rst_n(rst_n), .pf_tight(pf_tight), .pf_loose(pf_loose),
        .vlow(vlow), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .arr_busy(arr_busy), .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n),
        .dq_oe(dq_oe), .bkup_sel(bkup_sel), .ready(ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = MD_LOCK; m_cnt = 0; m_gwr = 0; m_arm = 0;
            s1 = 1; s2 = 1; v1 = 1; v2 = 1;
        end else begin : upd
            bit pfs, hw, live;
            pfs = s2;
            hw  = !ce_n && !we_n;
            case (m_mode)
                MD_LOCK: if (!pfs) begin m_mode = MD_REC; m_cnt = 0; end
                MD_REC: begin
                    if (pfs) m_mode = MD_LOCK;
                    else if (m_cnt == REC - 1) m_mode = MD_RUN;
                    else m_cnt++;
                end
                MD_RUN: if (pfs) begin
                    if (hw || arr_busy) begin
                        m_mode = MD_GR; m_cnt = 0; m_gwr = hw;
                    end else m_mode = MD_LOCK;
                end
                default: begin
                    live = (m_gwr && hw) || arr_busy;
                    if (!live || m_cnt == WPT - 1) begin
                        m_mode = MD_LOCK; m_gwr = 0;
                    end else begin
                        m_cnt++; m_gwr = m_gwr && hw;
                    end
                end
            endcase
            if (!pfs) m_arm = 1;
            s2 = s1; s1 = TOL ? pf_loose : pf_tight;
            v2 = v1; v1 = vlow;
        end
    end

    task automatic cyc(input bit c, input bit w, input bit o, input bit pt,
                       input bit pl, input bit vl, input bit bz);
        bit run, gr, hw, e_we, e_ce, e_oe, e_bk, e_rdy;
        @(negedge clk);
        ce_n = c; we_n = w; oe_n = o; pf_tight = pt; pf_loose = pl;
        vlow = vl; arr_busy = bz;
        #1;
        run   = (m_mode == MD_RUN);
        gr    = (m_mode == MD_GR);
        hw    = !ce_n && !we_n;
        e_we  = !((run && hw) || (gr && m_gwr && hw));
        e_ce  = !((run && !ce_n) || (gr && m_gwr && hw));
        e_oe  = run && !ce_n && !oe_n && we_n;
        e_bk  = m_arm && v2;
        e_rdy = run;
        vectors++;
        if (arr_we_n !== e_we || arr_ce_n !== e_ce || dq_oe !== e_oe ||
            bkup_sel !== e_bk || ready !== e_rdy) begin
            misses++;
            $display("FAIL %s t=%0t got we_n=%b ce_n=%b oe=%b bk=%b rdy=%b exp we_n=%b ce_n=%b oe=%b bk=%b rdy=%b",
                     tag, $time, arr_we_n, arr_ce_n, dq_oe, bkup_sel, ready,
                     e_we, e_ce, e_oe, e_bk, e_rdy);
        end
    endtask

    task automatic idle(input int n, input bit pt);
        for (int i = 0; i < n; i++) cyc(1, 1, 1, pt, 0, 0, 0);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        misses++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 1, 1, 0);
        @(negedge clk); rst_n = 1'b1;
        // R10: backup not selected before arming
        tag = "R10";
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 1, 1, 0);
        // R11: write attempts during lock and recovery
        tag = "R11";
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 1, 0, 0);
        for (int i = 0; i < 30; i++) cyc(0, i[0], 0, 0, 1, 0, 0);
        // R9: remainder of recovery into run
        tag = "R9";
        idle(REC, 0);
        // R3: unselected flag toggling is ignored
        tag = "R3";
        for (int i = 0; i < 10; i++) cyc(0, i[1], 1, 0, i[0], 0, 0);
        // R4: access patterns in run
        tag = "R4";
        for (int i = 0; i < 16; i++) cyc(i[0], i[1], i[2], 0, 0, 0, 0);
        // R5: idle failure, inputs ignored
        tag = "R5";
        for (int i = 0; i < 12; i++) cyc(i[0], i[1], i[2], 1, 0, 0, 0);
        // R10: armed latch selects backup on low supply
        tag = "R10";
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1, 0, 1, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        // R9: interrupted recovery restarts
        tag = "R9";
        idle(20, 0);
        idle(3, 1);
        idle(REC + 6, 0);
        // R2: single-cycle fail pulse
        tag = "R2";
        cyc(1, 1, 1, 1, 0, 0, 0);
        idle(6, 0);
        idle(REC + 4, 0);
        // R6: write in flight finishes, later write blocked
        tag = "R6";
        cyc(0, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 1, 0, 0, 0);
        idle(REC + 6, 0);
        // R7: held write forced off by timeout
        tag = "R7";
        cyc(0, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < WPT + 6; i++) cyc(0, 0, 1, 1, 0, 0, 0);
        idle(REC + 6, 0);
        // R8: array busy holds grace without strobes
        tag = "R8";
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 1, 0, 0, 1);
        cyc(1, 1, 1, 1, 0, 0, 0);
        idle(REC + 6, 0);
        for (int i = 0; i < WPT + 6; i++) cyc(0, 1, 0, 1, 0, 0, 1);
        idle(3, 1);
        idle(REC + 6, 0);
        summary();
        $finish;
    end

endmodule